// File: doc/BRIEF.md
# I2C Controller Host Register Interface

This block is the processor-facing register front end of a parallel-bus to I2C controller. An 8-bit CPU bus reaches it through a 2-bit address with separate read and write strobes. Four addresses are decoded:

- **Address 0** holds two registers. A read returns the read-only status register. A write loads the write-only indirect pointer.
- **Address 1** is the read/write serial data register.
- **Address 2** is a window into a small bank of indirect registers. The pointer selects which entry the window reaches.
- **Address 3** is reserved.

The serial bit engine is not part of this block. It is represented by four ports:

- a status code;
- a received byte;
- a shift-busy flag;
- a pulse that marks entry into a new state.

Entering any state other than idle sets an internal interrupt flag, and the flag drives an active-low interrupt pin. The data register is open to CPU writes only while that flag is set. Whenever the engine reports a new state, the data register captures the byte that was just transferred. The data register contents are always presented to the engine as the next byte to send.

Top module: `i2c_host_regs`

## Requirements
- R1: A synchronous active-high `rst` sets the status to F8h (code 3Eh), clears the pointer, the data register and every indirect entry, and drives `irq_n` high.
- R2: A read of address 0 returns `{code[5:0], 2'b00}`. Bits 1:0 always read zero, and the read has no side effect.
- R3: On a clock edge where `eng_set` is high and `eng_code` is not 3Eh, the code and `eng_rxdata` are captured and `irq_n` is low from the next cycle on.
- R4: On a clock edge where `eng_set` is high with `eng_code` equal to 3Eh (status F8h, idle), the code is captured, the interrupt flag clears and `irq_n` is high from the next cycle on.
- R5: `eng_busy` high without `eng_set` clears the interrupt flag (so `irq_n` goes high) and leaves the stored status unchanged.
- R6: A write to address 0 loads the pointer from `cpu_wdata[2:0]` and ignores bits 7:3. It does not change the status read back from address 0.
- R7: Reads and writes of address 2 access indirect entry number `pointer` (0 to 7). The entries are independent of one another.
- R8: A CPU write to address 1 updates the data register only while the interrupt flag is set, and is ignored while it is clear. `eng_set` in the same cycle takes priority over the CPU write.
- R9: A read of address 1 returns the data register, and `eng_txdata` always equals the data register.
- R10: A read of address 3 returns zero, and writes to address 3 change nothing. `cpu_rdata` is zero whenever `cpu_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 2 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the address |
| irq_n | output | 1 | Interrupt, active low |
| eng_set | input | 1 | Engine entered a new state this cycle |
| eng_code | input | 6 | Status code of the new state |
| eng_rxdata | input | 8 | Byte just transferred on the bus |
| eng_busy | input | 1 | Engine is shifting a byte |
| eng_txdata | output | 8 | Data register contents for the engine |

## Verification
The bench runs a behavioural model and compares `cpu_rdata`, `irq_n` and `eng_txdata` with it on every clock. The directed patterns are chosen to tell apart confusions that a simple decoder could make:

- **Shared address 0.** A pointer write with the reserved bits set is followed by a status read. This separates the pointer from the status, and checks that bits 7:3 of the pointer write are masked.
- **Indirect bank.** Different values are written to two pointer slots and read back. This catches a window that ignores the pointer.
- **Data-register lock.** Data writes are attempted while the flag is clear, while it is set, and in the same cycle as a state entry. These three cases expose a missing lock and a wrong priority.
- **Interrupt codes.** The idle code and non-idle codes are applied, followed by a long random mix of strobes, engine events and addresses.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
  parameter int DW     = 8,
  parameter int CW     = 6,
  parameter int PW     = 3,
  parameter logic [CW-1:0] IDLE_CODE = 6'h3E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq_n,
  input  logic          eng_set,
  input  logic [CW-1:0] eng_code,
  input  logic [DW-1:0] eng_rxdata,
  input  logic          eng_busy,
  output logic [DW-1:0] eng_txdata
);
  localparam int NREG = 1 << PW;
  localparam int PAD  = DW - CW;

  logic [CW-1:0] code_q;
  logic          flag_q;
  logic [DW-1:0] data_q;
  logic [PW-1:0] ptr_q;
  logic [DW-1:0] bank_q [NREG];

  wire wr_ptr  = cpu_wr && cpu_addr == 2'd0;
  wire wr_data = cpu_wr && cpu_addr == 2'd1 && flag_q;
  wire wr_ind  = cpu_wr && cpu_addr == 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= IDLE_CODE;
      flag_q <= 1'b0;
      data_q <= '0;
    end else if (eng_set) begin
      code_q <= eng_code;
      flag_q <= eng_code != IDLE_CODE;
      data_q <= eng_rxdata;
    end else begin
      if (eng_busy) flag_q <= 1'b0;
      if (wr_data)  data_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (wr_ptr) ptr_q <= cpu_wdata[PW-1:0];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_ind
    always_ff @(posedge clk) begin
      if (rst)                                     bank_q[i] <= '0;
      else if (wr_ind && ptr_q == PW'(i))          bank_q[i] <= cpu_wdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      case (cpu_addr)
        2'd0:    cpu_rdata = {code_q, {PAD{1'b0}}};
        2'd1:    cpu_rdata = data_q;
        2'd2:    cpu_rdata = bank_q[ptr_q];
        default: cpu_rdata = '0;
      endcase
    end
  end

  assign irq_n      = ~flag_q;
  assign eng_txdata = data_q;

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 2'd0) |-> cpu_rdata[1:0] == 2'b00);

  a_r3_irq_on_state: assert property (@(posedge clk) disable iff (rst)
    (eng_set && eng_code != IDLE_CODE) |=> !irq_n);

  a_r4_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
    (eng_set && eng_code == IDLE_CODE) |=> irq_n);

  a_r5_busy_clears: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && !eng_set) |=> (irq_n && $stable(code_q)));

  a_r6_ptr_load: assert property (@(posedge clk) disable iff (rst)
    wr_ptr |=> ptr_q == $past(cpu_wdata[PW-1:0]));

  a_r8_data_locked: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !eng_set) |=> $stable(eng_txdata));

  a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |-> cpu_rdata == '0);
endmodule

// File: tb/test_i2c_host_regs.sv
module test_i2c_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_addr = '0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, eng_rxdata = '0;
  logic       eng_set = 1'b0, eng_busy = 1'b0;
  logic [5:0] eng_code = '0;
  logic [7:0] cpu_rdata, eng_txdata;
  logic       irq_n;

  i2c_host_regs i_i2c_host_regs (.*);

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [5:0] m_code;
  logic       m_flag;
  logic [7:0] m_data;
  int         m_ptr;
  logic [7:0] m_bank [8];

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] a, logic rd, logic wr, logic [7:0] wd,
                      logic set, logic [5:0] code, logic [7:0] rx, logic busy);
    logic [7:0] er;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    eng_set = set; eng_code = code; eng_rxdata = rx; eng_busy = busy;
    #1;
    er = 8'h00;
    if (rd) begin
      if (a == 0) er = {m_code, 2'b00};
      else if (a == 1) er = m_data;
      else if (a == 2) er = m_bank[m_ptr];
    end
    chk(tag, "cpu_rdata", cpu_rdata, er);
    chk(tag, "irq_n", {7'd0, irq_n}, {7'd0, !m_flag});
    chk("R9", "eng_txdata", eng_txdata, m_data);
    @(posedge clk);
    if (wr && a == 2) m_bank[m_ptr] = wd;
    if (wr && a == 0) m_ptr = int'(wd[2:0]);
    if (set) begin
      m_code = code; m_flag = (code != 6'h3E); m_data = rx;
    end else begin
      if (wr && a == 1 && m_flag) m_data = wd;
      if (busy) m_flag = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [1:0] a);
    step(tag, a, 1'b1, 1'b0, 8'h00, 1'b0, 6'h00, 8'h00, 1'b0);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [7:0] d);
    step(tag, a, 1'b0, 1'b1, d, 1'b0, 6'h00, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    m_code = 6'h3E; m_flag = 1'b0; m_data = '0; m_ptr = 0;
    foreach (m_bank[i]) m_bank[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2);
    wr("R6", 2'd0, 8'hFD);
    rd("R6", 2'd0);
    wr("R7", 2'd2, 8'hA5);
    wr("R6", 2'd0, 8'h02);
    wr("R7", 2'd2, 8'h3C);
    rd("R7", 2'd2);
    wr("R7", 2'd0, 8'h05);
    rd("R7", 2'd2);
    wr("R8", 2'd1, 8'h77);
    rd("R8", 2'd1);
    step("R3", 2'd0, 1'b1, 1'b0, 8'h00, 1'b1, 6'h02, 8'h91, 1'b0);
    rd("R3", 2'd0); rd("R3", 2'd1);
    wr("R8", 2'd1, 8'h55);
    rd("R8", 2'd1);
    step("R8", 2'd1, 1'b0, 1'b1, 8'hEE, 1'b1, 6'h0A, 8'h42, 1'b0);
    rd("R8", 2'd1);
    step("R5", 2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 6'h00, 8'h00, 1'b1);
    rd("R5", 2'd0);
    wr("R8", 2'd1, 8'h13);
    rd("R8", 2'd1);
    step("R3", 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h11, 8'h66, 1'b0);
    step("R4", 2'd0, 1'b1, 1'b0, 8'h00, 1'b1, 6'h3E, 8'h24, 1'b0);
    rd("R4", 2'd0); rd("R2", 2'd0);
    wr("R10", 2'd3, 8'hFF);
    rd("R10", 2'd3); rd("R10", 2'd2); rd("R10", 2'd1);
    step("R10", 2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 6'h00, 8'h00, 1'b0);
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] c;
      c = ($urandom_range(0, 3) == 0) ? 6'h3E : 6'($urandom);
      step("R2 R3 R5 R7 R8 mix", 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           $urandom_range(0, 5) == 0, c, 8'($urandom), $urandom_range(0, 7) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule